// File: doc/BRIEF.md
# Tone Presence Qualification Timer

This block turns raw, per-sample "tone in band and above threshold" indications from two upstream tone detectors into clean presence outputs with timing hysteresis. One channel qualifies the call progress tone and the other qualifies a special single-frequency tone (the 1300 Hz answer tone). A raw indication must stay continuously asserted for a programmable number of millisecond ticks before the output rises. After the raw indication goes away, the output holds for another programmable number of ticks before it falls. Any return of the raw indication during that hold cancels the release.

A prescaler divides the system clock into a one-millisecond tick, and all intervals are counted in ticks. With the defaults this gives a nominal 50 ms qualify-on delay and a 50 ms release hold. Under these settings a tone lasting 70 ms or more is always reported, and a burst of 35 ms or less never is. The special-tone output is masked while the progress-tone output is high. A common detection enable forces both outputs low and discards any qualification in progress. Each output also has a one-cycle pulse on its rising edge, which a status flag elsewhere can latch.

Top module: `toneQualTop`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `progPresent`, `specPresent`, `progRise` and `specRise` are 0.
- R2: When a raw input rises while its channel is idle and then stays high, the channel output rises no earlier than (QUAL_TICKS-1)*TICK_DIV+1 cycles after the first clock edge that samples the raw input high, and no later than QUAL_TICKS*TICK_DIV cycles after that edge.
- R3: A raw burst of (QUAL_TICKS-1)*TICK_DIV cycles or fewer never makes the output rise. A raw input seen low at even a single clock edge during qualification restarts the count from zero.
- R4: After the raw input of an asserted channel falls, the output stays high for at least (HOLD_TICKS-1)*TICK_DIV+1 cycles and falls no later than HOLD_TICKS*TICK_DIV cycles after the first edge that samples the raw input low.
- R5: If the raw input returns high during the release hold, the release is cancelled. A later loss then starts a fresh, full hold interval.
- R6: `specPresent` is 0 in every cycle in which `progPresent` is 1, whatever `specRaw` does.
- R7: When `detEnable` is sampled 0, both outputs are 0 after that edge, and all qualification state is discarded. After `detEnable` returns to 1, a full qualify-on interval (R2) is needed again.
- R8: `progRise` (or `specRise`) is 1 for exactly the one cycle in which `progPresent` (or `specPresent`) changes from 0 to 1, and is 0 at every other time.
- R9: The special channel keeps qualifying and holding while it is masked. When `progPresent` falls and the special channel is qualified, `specPresent` rises in the same cycle, with no new qualify-on delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominally 3.579545 MHz) |
| rstN | input | 1 | Active-low power-down reset; clears counters and outputs |
| detEnable | input | 1 | Detection enable; 0 holds both outputs low |
| progRaw | input | 1 | Raw call progress tone indication from the detector |
| specRaw | input | 1 | Raw special tone indication from the detector |
| progPresent | output | 1 | Qualified call progress tone presence |
| specPresent | output | 1 | Qualified special tone presence, masked by `progPresent` |
| progRise | output | 1 | One-cycle pulse when `progPresent` rises |
| specRise | output | 1 | One-cycle pulse when `specPresent` rises |

## Verification
Two functions can act in the same cycle: the progress channel's qualify or release, and the masking of the special channel. The bench first qualifies the special tone. It then qualifies the progress tone on top of it, so that one edge raises `progPresent` and drops `specPresent`. Later it releases the progress tone, so that one edge drops `progPresent` and raises `specPresent`. Samples are taken at both ends of the tick-quantization window. At the early end the old output pair must still show; at the late end the swapped pair must show. A monitor also checks in every cycle that the two outputs are never both high and that each rise pulse matches a 0-to-1 change of its output.

// File: rtl/toneq_pkg.sv
package toneq_pkg;

  localparam int NUM_CH  = 2;
  localparam int CH_PROG = 0;
  localparam int CH_SPEC = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_QUAL = 2'd1,
    ST_ON   = 2'd2,
    ST_HOLD = 2'd3
  } toneState_t;

  // strobes from control to the tick counters of one channel
  typedef struct packed {
    logic clrCnt;   // restart the interval count
    logic incCnt;   // count on the next tick
    logic selHold;  // compare against the hold interval instead of the qualify interval
  } cntCmd_t;

endpackage

// File: rtl/toneQualDatapath.sv
module toneQualDatapath
  import toneq_pkg::*;
#(
  parameter int TICK_DIV   = 3580,
  parameter int QUAL_TICKS = 50,
  parameter int HOLD_TICKS = 50
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cntCmd_t [NUM_CH-1:0] cmd,
  output logic    [NUM_CH-1:0] lastTick
);

  localparam int MAX_TICKS = (QUAL_TICKS > HOLD_TICKS) ? QUAL_TICKS : HOLD_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int DIV_W     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_TICKS - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] MAX_LAST  = CNT_W'(MAX_TICKS - 1);

  logic tick;

  // shared millisecond prescaler
  generate
    if (TICK_DIV > 1) begin : gPrescale
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                divCnt <= '0;
        else if (divCnt == DIV_LAST) divCnt <= '0;
        else                      divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DIV_LAST);

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN) tick |=> !tick); // R2
    end else begin : gNoPrescale
      assign tick = 1'b1;
    end
  endgenerate

  // one interval counter per channel
  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCnt
      logic [CNT_W-1:0] cnt;
      logic [CNT_W-1:0] limit;

      assign limit = cmd[ch].selHold ? HOLD_LAST : QUAL_LAST;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                       cnt <= '0;
        else if (cmd[ch].clrCnt)         cnt <= '0;
        else if (cmd[ch].incCnt && tick) cnt <= cnt + 1'b1;
      end

      assign lastTick[ch] = tick && (cnt == limit);

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN) cnt <= MAX_LAST); // R3
    end
  endgenerate

endmodule

// File: rtl/toneQualCtrl.sv
module toneQualCtrl
  import toneq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 detEnable,
  input  logic    [NUM_CH-1:0] rawIn,
  input  logic    [NUM_CH-1:0] lastTick,
  output cntCmd_t [NUM_CH-1:0] cmd,
  output logic    [NUM_CH-1:0] outReg,
  output logic    [NUM_CH-1:0] riseReg
);

  logic [NUM_CH-1:0] presNext;
  logic [NUM_CH-1:0] gatedNext;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
      toneState_t st;
      toneState_t stNext;
      cntCmd_t    c;

      always_comb begin
        stNext = st;
        c      = '0;
        unique case (st)
          ST_IDLE: begin
            c.clrCnt = 1'b1;
            if (rawIn[ch]) stNext = ST_QUAL;
          end
          ST_QUAL: begin
            if (!rawIn[ch]) begin
              stNext   = ST_IDLE;
              c.clrCnt = 1'b1;
            end else if (lastTick[ch]) begin
              stNext = ST_ON;
            end else begin
              c.incCnt = 1'b1;
            end
          end
          ST_ON: begin
            if (!rawIn[ch]) begin
              stNext   = ST_HOLD;
              c.clrCnt = 1'b1;
            end
          end
          ST_HOLD: begin
            c.selHold = 1'b1;
            if (rawIn[ch]) begin
              stNext = ST_ON;
            end else if (lastTick[ch]) begin
              stNext   = ST_IDLE;
              c.clrCnt = 1'b1;
            end else begin
              c.incCnt = 1'b1;
            end
          end
          default: stNext = ST_IDLE;
        endcase
        if (!detEnable) begin
          stNext   = ST_IDLE;
          c.clrCnt = 1'b1;
          c.incCnt = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) st <= ST_IDLE;
        else       st <= stNext;
      end

      assign cmd[ch]      = c;
      assign presNext[ch] = (stNext == ST_ON) || (stNext == ST_HOLD);

      AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) riseReg[ch] |=> !riseReg[ch]); // R8
      AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rstN) riseReg[ch] |-> (outReg[ch] && !$past(outReg[ch]))); // R8
    end
  endgenerate

  // cross suppression: the progress channel masks the special channel
  assign gatedNext[CH_PROG] = presNext[CH_PROG];
  assign gatedNext[CH_SPEC] = presNext[CH_SPEC] && !presNext[CH_PROG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg  <= '0;
      riseReg <= '0;
    end else begin
      outReg  <= gatedNext;
      riseReg <= gatedNext & ~outReg;
    end
  end

  AST_SPEC_MASKED: assert property (@(posedge clk) disable iff (!rstN) outReg[CH_SPEC] |-> !outReg[CH_PROG]); // R6
  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN) !detEnable |=> (outReg == '0)); // R7
  AST_PROG_RISE_RAW: assert property (@(posedge clk) disable iff (!rstN) $rose(outReg[CH_PROG]) |-> $past(rawIn[CH_PROG])); // R2
  AST_PROG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN) $fell(outReg[CH_PROG]) |-> (!$past(rawIn[CH_PROG]) || !$past(detEnable))); // R4

endmodule

// File: rtl/toneQualTop.sv
module toneQualTop
  import toneq_pkg::*;
#(
  parameter int TICK_DIV   = 3580,
  parameter int QUAL_TICKS = 50,
  parameter int HOLD_TICKS = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic detEnable,
  input  logic progRaw,
  input  logic specRaw,
  output logic progPresent,
  output logic specPresent,
  output logic progRise,
  output logic specRise
);

  cntCmd_t [NUM_CH-1:0] cmd;
  logic    [NUM_CH-1:0] lastTick;
  logic    [NUM_CH-1:0] rawIn;
  logic    [NUM_CH-1:0] outReg;
  logic    [NUM_CH-1:0] riseReg;

  assign rawIn[CH_PROG] = progRaw;
  assign rawIn[CH_SPEC] = specRaw;

  toneQualCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .detEnable(detEnable),
    .rawIn    (rawIn),
    .lastTick (lastTick),
    .cmd      (cmd),
    .outReg   (outReg),
    .riseReg  (riseReg)
  );

  toneQualDatapath #(
    .TICK_DIV  (TICK_DIV),
    .QUAL_TICKS(QUAL_TICKS),
    .HOLD_TICKS(HOLD_TICKS)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .lastTick(lastTick)
  );

  assign progPresent = outReg[CH_PROG];
  assign specPresent = outReg[CH_SPEC];
  assign progRise    = riseReg[CH_PROG];
  assign specRise    = riseReg[CH_SPEC];

endmodule

// File: tb/tb_toneQualTop.sv
`timescale 1ns/1ps
module tb_toneQualTop;

  localparam int DIV  = 4;
  localparam int QUAL = 5;
  localparam int HOLD = 5;
  // quantization window edges, relative to the cycle in which the input is driven
  localparam int WIN_LO = 1 + (QUAL - 1) * DIV;  // last cycle still guaranteed unchanged
  localparam int WIN_HI = 1 + QUAL * DIV;        // first cycle guaranteed changed

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic detEnable = 1'b0;
  logic progRaw = 1'b0;
  logic specRaw = 1'b0;
  logic progPresent, specPresent, progRise, specRise;

  always #2.5 clk = ~clk;

  toneQualTop #(.TICK_DIV(DIV), .QUAL_TICKS(QUAL), .HOLD_TICKS(HOLD)) dut (
    .clk(clk), .rstN(rstN), .detEnable(detEnable),
    .progRaw(progRaw), .specRaw(specRaw),
    .progPresent(progPresent), .specPresent(specPresent),
    .progRise(progRise), .specRise(specRise)
  );

  typedef struct {
    int    at;
    bit    eP;
    bit    eS;
    string tag;
  } expItem_t;

  expItem_t sbQ[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int progRiseCnt = 0;
  int specRiseCnt = 0;
  int pulseBad = 0;
  int maskBad = 0;
  bit prevP = 1'b0;
  bit prevS = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expectAt(input int at, input bit p, input bit s, input string tag);
    expItem_t it;
    it.at = at; it.eP = p; it.eS = s; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard items and watches pulses and masking every cycle
  always @(posedge clk) begin
    #3;
    while (sbQ.size() > 0 && sbQ[0].at <= cyc) begin
      expItem_t it;
      it = sbQ.pop_front();
      checks++;
      if (it.at != cyc || progPresent !== it.eP || specPresent !== it.eS) begin
        errors++;
        $display("FAIL %s at cycle %0d actual prog=%b spec=%b expected prog=%b spec=%b",
                 it.tag, it.at, progPresent, specPresent, it.eP, it.eS);
      end
    end
    if (progRise !== (progPresent && !prevP)) pulseBad++;
    if (specRise !== (specPresent && !prevS)) pulseBad++;
    if (progPresent && specPresent) maskBad++;
    if (progRise === 1'b1) progRiseCnt++;
    if (specRise === 1'b1) specRiseCnt++;
    prevP = progPresent;
    prevS = specPresent;
  end

  initial begin
    int b;
    // R1: reset state
    step(3);
    checkVal("R1 progPresent in reset", progPresent, 0);
    checkVal("R1 specPresent in reset", specPresent, 0);
    checkVal("R1 rise pulses in reset", progRise | specRise, 0);
    rstN = 1'b1;
    detEnable = 1'b1;
    step(1);
    checkVal("R1 outputs after reset", {progPresent, specPresent, progRise, specRise}, 0);

    // R2: qualify-on window
    b = cyc;
    expectAt(b + WIN_LO, 0, 0, "R2 not yet asserted");
    expectAt(b + WIN_HI, 1, 0, "R2 asserted");
    progRaw = 1'b1;
    step(25);

    // R4: release hold window
    b = cyc;
    expectAt(b + 1 + (HOLD - 1) * DIV, 1, 0, "R4 still held");
    expectAt(b + 1 + HOLD * DIV, 0, 0, "R4 released");
    progRaw = 1'b0;
    step(25);

    // R3: short bursts and a single-cycle dropout
    b = cyc;
    expectAt(b + 12, 0, 0, "R3 short burst 1");
    expectAt(b + 25, 0, 0, "R3 short burst 2");
    expectAt(b + 54, 0, 0, "R3 dropout restart");
    expectAt(b + 58, 0, 0, "R3 dropout restart late");
    progRaw = 1'b1; step(10);
    progRaw = 1'b0; step(3);
    progRaw = 1'b1; step(10);
    progRaw = 1'b0; step(7);
    progRaw = 1'b1; step(12);
    progRaw = 1'b0; step(1);
    progRaw = 1'b1; step(12);
    progRaw = 1'b0; step(25);

    // R5: return during hold cancels the release
    progRaw = 1'b1; step(25);
    b = cyc;
    expectAt(b + 21, 1, 0, "R5 release cancelled");
    expectAt(b + 37, 1, 0, "R5 fresh hold not expired");
    expectAt(b + 41, 0, 0, "R5 fresh hold expired");
    progRaw = 1'b0; step(10);
    progRaw = 1'b1; step(10);
    progRaw = 1'b0; step(25);

    // R6 / R9: masking and same-cycle swap
    b = cyc;
    expectAt(b + 21, 0, 1, "R9 special qualified");
    expectAt(b + 46, 1, 0, "R6 special masked by progress");
    expectAt(b + 67, 1, 0, "R6 progress still held, special masked");
    expectAt(b + 71, 0, 1, "R9 special back without new delay");
    expectAt(b + 96, 0, 0, "R4 special released");
    specRaw = 1'b1; step(25);
    progRaw = 1'b1; step(25);
    progRaw = 1'b0; step(25);
    specRaw = 1'b0; step(25);

    // R7: enable off clears, re-enable requalifies
    b = cyc;
    expectAt(b + 21, 0, 1, "R7 special on before disable");
    expectAt(b + 26, 0, 0, "R7 disable forces low");
    expectAt(b + 30 + WIN_LO, 0, 0, "R7 requalify not yet");
    expectAt(b + 30 + WIN_HI, 0, 1, "R7 requalified");
    specRaw = 1'b1; step(25);
    detEnable = 1'b0; step(5);
    detEnable = 1'b1; step(25);
    specRaw = 1'b0; step(30);

    while (sbQ.size() > 0) step(1);
    checkVal("R8 rise pulse matches output edge", pulseBad, 0);
    checkVal("R8 progRise pulse count", progRiseCnt, 3);
    checkVal("R8 specRise pulse count", specRiseCnt, 4);
    checkVal("R6 both outputs high cycles", maskBad, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule